// File: doc/BRIEF.md
# MFM write escape interpreter

This block sits between a DMA source and an MFM write serializer. The source delivers 16-bit words. Each word carries two stream bytes, and the upper byte is taken first. Most bytes are payload and pass straight through. The value 0x99 is a prefix: the byte after it is read as a command. A command can produce a sync byte with a missing clock, an address mark, or the two CRC bytes. It can also open a window in which a fixed count of payload bytes passes with no escape decoding, or it can end the write.

The output is one byte per handshake. Each byte carries a mark-kind code, a flag for CRC bytes and a flag that tells the external CRC engine to preset itself. The block drives a write-gate signal that the serializer uses to enable the head current. The CRC arithmetic lives outside the block, and its current value arrives on `crc_in`.

A write session opens with a start pulse and closes with the stop command. Outside a session, incoming words are accepted and thrown away.

Top module: `mfmw_escape_interp`

## Requirements
- R1: After reset `wr_gate`, `out_valid` and `cmd_err` are low and `in_ready` is high.
- R2: A word accepted on clock edge k yields its upper byte at the output after edge k+1 and its lower byte after edge k+2, provided `out_ready` is high. A byte other than 0x99 appears unchanged with `out_mark` = 0, `out_crc` = 0 and `out_crc_init` = 0. `in_ready` stays low while a word is held.
- R3: The byte 0x99 produces no output, and the byte after it is treated as a command. Command 0xA1 emits 0xA1 with `out_mark` = 1 (sync byte with a missing clock). `out_crc_init` is 1 only on the first A1 of a run of consecutive A1 outputs.
- R4: Command 0xC2 emits 0xC2 with `out_mark` = 2 (index sync). Commands 0xFB, 0xFE and 0xFC each emit their own value with `out_mark` = 3 (address mark).
- R5: Command 0x0F emits nothing. The next RAW_LEN bytes (default 512) then pass as plain data even if they equal 0x99. After that run, escape decoding resumes.
- R6: Command 0x04 emits two bytes, both with `out_crc` = 1: first `crc_in[15:8]`, then `crc_in[7:0]`. Both halves are sampled on the edge that processes the command.
- R7: Command 0x08 emits nothing, and `wr_gate` falls on the edge that processes it.
- R8: While `wr_gate` is low, words are still accepted, and their bytes are discarded with no output.
- R9: A command byte not listed above emits nothing and sets `cmd_err`. The flag stays set until a start pulse or reset.
- R10: A `wr_start` pulse while `wr_gate` is low raises `wr_gate` on the next edge and clears `cmd_err`, any pending escape and the raw-run count.
- R11: While `out_valid` is high and `out_ready` is low, the output byte and its flags hold steady and no byte is lost.
- R12: `out_valid` is never high while `wr_gate` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Opens a write session |
| in_valid | input | 1 | Input word valid |
| in_word | input | WORD_W | Input word, upper byte first |
| in_ready | output | 1 | Block can accept a word |
| crc_in | input | CRC_W | Current CRC value from the external engine |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Serializer takes the output byte |
| out_byte | output | 8 | Output byte |
| out_mark | output | 2 | 0 data, 1 A1 sync, 2 index sync, 3 address mark |
| out_crc | output | 1 | Byte is a CRC byte |
| out_crc_init | output | 1 | Preset the CRC before this byte |
| wr_gate | output | 1 | Write enable to the serializer |
| cmd_err | output | 1 | Sticky flag for an undefined command |

## Verification
Every result has a fixed position relative to the edge k that accepts a word. The upper byte's result is due after edge k+1 and the lower byte's after edge k+2, whether that result is an output byte, a change of `wr_gate` or the setting of `cmd_err`. The first CRC byte is due after the edge that processes the command, and the second after the next edge on which the output is free.

The latency and gate checks sample on the falling edge that follows the edge where the result is due. Streams are compared against an expected list built from the requirements, using a monitor that logs each handshake at the falling edge. The bench changes `out_ready` only just after a rising edge, so that a logged handshake never races a change of the ready signal.

// File: rtl/mfmw_pkg.sv
package mfmw_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] ESC_BYTE   = 8'h99;
    localparam logic [7:0] CMD_SYNC   = 8'hA1;
    localparam logic [7:0] CMD_ISYNC  = 8'hC2;
    localparam logic [7:0] CMD_DAM    = 8'hFB;
    localparam logic [7:0] CMD_IDAM   = 8'hFE;
    localparam logic [7:0] CMD_IAM    = 8'hFC;
    localparam logic [7:0] CMD_RAW    = 8'h0F;
    localparam logic [7:0] CMD_CRC    = 8'h04;
    localparam logic [7:0] CMD_STOP   = 8'h08;

    typedef enum logic [1:0] {
        MK_NONE  = 2'd0,
        MK_SYNC  = 2'd1,
        MK_ISYNC = 2'd2,
        MK_ADDR  = 2'd3
    } mark_e;

    typedef enum logic [2:0] {
        ACT_NOP,
        ACT_DATA,
        ACT_MARK,
        ACT_RAW,
        ACT_CRC,
        ACT_STOP,
        ACT_BAD
    } act_e;

    typedef struct packed {
        act_e  act;
        mark_e mark;
    } decode_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        mark_e             mark;
        logic              crc;
        logic              crc_init;
    } obyte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_CRC_LO
    } wstate_e;

    // Maps the byte that follows an escape prefix onto an action.
    function automatic decode_t decode_cmd(input logic [BYTE_W-1:0] b);
        decode_t d;
        d.mark = MK_NONE;
        case (b)
            CMD_SYNC:  begin d.act = ACT_MARK; d.mark = MK_SYNC;  end
            CMD_ISYNC: begin d.act = ACT_MARK; d.mark = MK_ISYNC; end
            CMD_DAM,
            CMD_IDAM,
            CMD_IAM:   begin d.act = ACT_MARK; d.mark = MK_ADDR;  end
            CMD_RAW:   d.act = ACT_RAW;
            CMD_CRC:   d.act = ACT_CRC;
            CMD_STOP:  d.act = ACT_STOP;
            default:   d.act = ACT_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mfmw_word_unpack.sv
module mfmw_word_unpack
    import mfmw_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              take,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_val
);

    localparam int NB = WORD_W / BYTE_W;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     idx_q;
    logic              full_q;
    logic              last_lane;
    logic [BYTE_W-1:0] lane [NB];

    // Lane 0 is the most significant byte of the word.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign lane[g] = word_q[WORD_W-1-BYTE_W*g -: BYTE_W];
    end

    assign byte_val   = lane[idx_q];
    assign byte_valid = full_q;
    assign in_ready   = !full_q;
    assign last_lane  = (idx_q == IW'(NB-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            word_q <= in_word;
            idx_q  <= '0;
            full_q <= 1'b1;
        end else if (take && full_q) begin
            if (last_lane) begin
                full_q <= 1'b0;
            end else begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    a_r2_load_presents: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> byte_valid);

    a_r2_byte_steady: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !take) |=> (byte_valid && $stable(byte_val)));

endmodule

// File: rtl/mfmw_raw_counter.sv
module mfmw_raw_counter #(
    parameter int RAW_LEN = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load,
    input  logic dec,
    output logic active
);

    localparam int CW = $clog2(RAW_LEN + 1);

    logic [CW-1:0] cnt_q;

    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(RAW_LEN);
        end else if (dec && active) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(RAW_LEN));

    a_r5_run_opens_on_load: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(load));

endmodule

// File: rtl/mfmw_esc_decode.sv
module mfmw_esc_decode
    import mfmw_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              esc_pend,
    input  logic              raw_on,
    output decode_t           dec,
    output logic              esc_seen
);

    always_comb begin
        esc_seen = 1'b0;
        dec.act  = ACT_DATA;
        dec.mark = MK_NONE;
        if (raw_on) begin
            dec.act = ACT_DATA;
        end else if (esc_pend) begin
            dec = decode_cmd(byte_val);
        end else if (byte_val == ESC_BYTE) begin
            dec.act  = ACT_NOP;
            esc_seen = 1'b1;
        end
    end

endmodule

// File: rtl/mfmw_escape_interp.sv
module mfmw_escape_interp
    import mfmw_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CRC_W   = 16,
    parameter int RAW_LEN = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic [CRC_W-1:0]  crc_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic [1:0]        out_mark,
    output logic              out_crc,
    output logic              out_crc_init,
    output logic              wr_gate,
    output logic              cmd_err
);

    localparam int CRC_LO_W = CRC_W - BYTE_W;

    wstate_e               state_q, state_d;
    logic                  esc_q, esc_d;
    logic                  err_q, err_d;
    logic                  prev_a1_q, prev_a1_d;
    logic [CRC_LO_W-1:0]   crc_lo_q, crc_lo_d;
    obyte_t                out_q, emit_b;
    logic                  out_valid_q;
    logic                  emit, out_free, take;
    logic                  raw_load, raw_dec, raw_clr, raw_on;
    logic                  byte_valid;
    logic [BYTE_W-1:0]     byte_val;
    decode_t               dec;
    logic                  esc_seen;

    mfmw_word_unpack #(.WORD_W(WORD_W)) u_unpack (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .in_ready   (in_ready),
        .take       (take),
        .byte_valid (byte_valid),
        .byte_val   (byte_val)
    );

    mfmw_raw_counter #(.RAW_LEN(RAW_LEN)) u_raw (
        .clk    (clk),
        .rst    (rst),
        .clr    (raw_clr),
        .load   (raw_load),
        .dec    (raw_dec),
        .active (raw_on)
    );

    mfmw_esc_decode u_dec (
        .byte_val (byte_val),
        .esc_pend (esc_q),
        .raw_on   (raw_on),
        .dec      (dec),
        .esc_seen (esc_seen)
    );

    assign out_free = !out_valid_q || out_ready;

    always_comb begin
        state_d   = state_q;
        esc_d     = esc_q;
        err_d     = err_q;
        prev_a1_d = prev_a1_q;
        crc_lo_d  = crc_lo_q;
        take      = 1'b0;
        emit      = 1'b0;
        emit_b    = '0;
        raw_load  = 1'b0;
        raw_dec   = 1'b0;
        raw_clr   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                // Outside a session bytes are drained and dropped.
                take = byte_valid;
                if (wr_start) begin
                    state_d   = ST_RUN;
                    esc_d     = 1'b0;
                    err_d     = 1'b0;
                    prev_a1_d = 1'b0;
                    raw_clr   = 1'b1;
                end
            end
            ST_RUN: begin
                if (byte_valid && out_free) begin
                    take    = 1'b1;
                    esc_d   = esc_seen;
                    raw_dec = raw_on;
                    case (dec.act)
                        ACT_DATA: begin
                            emit        = 1'b1;
                            emit_b.data = byte_val;
                        end
                        ACT_MARK: begin
                            emit            = 1'b1;
                            emit_b.data     = byte_val;
                            emit_b.mark     = dec.mark;
                            emit_b.crc_init = (dec.mark == MK_SYNC) && !prev_a1_q;
                        end
                        ACT_RAW: raw_load = 1'b1;
                        ACT_CRC: begin
                            emit        = 1'b1;
                            emit_b.data = crc_in[CRC_W-1 -: BYTE_W];
                            emit_b.crc  = 1'b1;
                            crc_lo_d    = crc_in[CRC_LO_W-1:0];
                            state_d     = ST_CRC_LO;
                        end
                        ACT_STOP: state_d = ST_IDLE;
                        ACT_BAD:  err_d   = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_CRC_LO: begin
                if (out_free) begin
                    emit        = 1'b1;
                    emit_b.data = BYTE_W'(crc_lo_q);
                    emit_b.crc  = 1'b1;
                    state_d     = ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (emit) begin
            prev_a1_d = (emit_b.mark == MK_SYNC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            esc_q       <= 1'b0;
            err_q       <= 1'b0;
            prev_a1_q   <= 1'b0;
            crc_lo_q    <= '0;
            out_q       <= '0;
            out_valid_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            esc_q     <= esc_d;
            err_q     <= err_d;
            prev_a1_q <= prev_a1_d;
            crc_lo_q  <= crc_lo_d;
            if (out_free) begin
                out_valid_q <= emit;
                if (emit) begin
                    out_q <= emit_b;
                end
            end
        end
    end

    assign out_valid    = out_valid_q;
    assign out_byte     = out_q.data;
    assign out_mark     = out_q.mark;
    assign out_crc      = out_q.crc;
    assign out_crc_init = out_q.crc_init;
    assign wr_gate      = (state_q != ST_IDLE);
    assign cmd_err      = err_q;

    a_r12_valid_gated: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> wr_gate);

    a_r11_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_byte) && $stable(out_mark) && $stable(out_crc)));

    a_r6_crc_pair_pending: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CRC_LO) |-> (out_valid && out_crc));

    a_r7_gate_falls_empty: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_gate) |-> !out_valid);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmd_err && !wr_start) |=> cmd_err);

    a_r10_start_opens: assert property (@(posedge clk) disable iff (rst)
        (wr_start && !wr_gate) |=> (wr_gate && !cmd_err));

    a_r3_mark_not_crc: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mark != 2'd0) |-> !out_crc);

endmodule

// File: tb/tb_mfmw_escape_interp.sv
module tb_mfmw_escape_interp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic [15:0] crc_in = '0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, out_crc, out_crc_init, wr_gate, cmd_err;
    logic [7:0]  out_byte;
    logic [1:0]  out_mark;

    mfmw_escape_interp dut (
        .clk          (clk),
        .rst          (rst),
        .wr_start     (wr_start),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .in_ready     (in_ready),
        .crc_in       (crc_in),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_byte     (out_byte),
        .out_mark     (out_mark),
        .out_crc      (out_crc),
        .out_crc_init (out_crc_init),
        .wr_gate      (wr_gate),
        .cmd_err      (cmd_err)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [11:0] cap [1024];
    logic [11:0] exp_q [1024];
    int cap_n = 0;
    int exp_n = 0;
    int gate_viol = 0;

    // Handshake log: {byte, mark, crc, crc_init}
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready && cap_n < 1024) begin
                cap[cap_n] = {out_byte, out_mark, out_crc, out_crc_init};
                cap_n = cap_n + 1;
            end
            if (out_valid && !wr_gate) gate_viol = gate_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_cap();
        cap_n = 0;
        exp_n = 0;
    endtask

    task automatic push(input logic [7:0] b, input logic [1:0] m,
                        input logic c, input logic i);
        exp_q[exp_n] = {b, m, c, i};
        exp_n++;
    endtask

    task automatic verify(input string req);
        int bad_i = -1;
        chk(cap_n == exp_n, req, "stream length", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (bad_i < 0 && cap[i] !== exp_q[i]) bad_i = i;
        end
        if (bad_i < 0) chk(1'b1, req, "stream content", 0, 0);
        else chk(1'b0, req, $sformatf("stream entry %0d", bad_i),
                 int'(cap[bad_i]), int'(exp_q[bad_i]));
    endtask

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic t_reset();
        chk(wr_gate == 1'b0, "R1", "wr_gate", wr_gate, 0);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk(cmd_err == 1'b0, "R1", "cmd_err", cmd_err, 0);
    endtask

    task automatic t_idle_discard();
        clr_cap();
        send_word(16'h1234);
        tick(4);
        chk(cap_n == 0, "R8", "bytes out before start", cap_n, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after drain", in_ready, 1);
    endtask

    task automatic t_start();
        chk(wr_gate == 1'b0, "R10", "gate before start", wr_gate, 0);
        pulse_start();
        chk(wr_gate == 1'b1, "R10", "gate after start", wr_gate, 1);
    endtask

    task automatic t_latency();
        clr_cap();
        send_word(16'h5A3C);
        chk(out_valid == 1'b0 && in_ready == 1'b0, "R2", "edge k valid/ready",
            {out_valid, in_ready}, 0);
        tick(1);
        chk(out_valid && out_byte == 8'h5A && out_mark == 2'd0, "R2", "edge k+1 byte",
            out_byte, 8'h5A);
        tick(1);
        chk(out_valid && out_byte == 8'h3C && !out_crc, "R2", "edge k+2 byte",
            out_byte, 8'h3C);
        tick(2);
    endtask

    task automatic t_backpressure();
        clr_cap();
        @(posedge clk); #1 out_ready = 1'b0;
        send_word(16'h1122);
        tick(4);
        chk(out_valid && out_byte == 8'h11, "R11", "stalled byte held", out_byte, 8'h11);
        chk(cap_n == 0, "R11", "no handshake while stalled", cap_n, 0);
        @(posedge clk); #1 out_ready = 1'b1;
        tick(4);
        push(8'h11, 2'd0, 1'b0, 1'b0);
        push(8'h22, 2'd0, 1'b0, 1'b0);
        verify("R11");
    endtask

    task automatic t_preamble();
        clr_cap();
        for (int i = 0; i < 5; i++) send_word(16'h4E4E);
        for (int i = 0; i < 6; i++) send_word(16'h0000);
        for (int i = 0; i < 3; i++) send_word(16'h99A1);
        send_word(16'h99FB);
        tick(4);
        for (int i = 0; i < 10; i++) push(8'h4E, 2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) push(8'h00, 2'd0, 1'b0, 1'b0);
        push(8'hA1, 2'd1, 1'b0, 1'b1);
        push(8'hA1, 2'd1, 1'b0, 1'b0);
        push(8'hA1, 2'd1, 1'b0, 1'b0);
        push(8'hFB, 2'd3, 1'b0, 1'b0);
        verify("R3");
    endtask

    task automatic t_marks();
        clr_cap();
        send_word(16'h99C2);
        send_word(16'h99FC);
        send_word(16'h99FE);
        send_word(16'h99A1);
        tick(4);
        push(8'hC2, 2'd2, 1'b0, 1'b0);
        push(8'hFC, 2'd3, 1'b0, 1'b0);
        push(8'hFE, 2'd3, 1'b0, 1'b0);
        push(8'hA1, 2'd1, 1'b0, 1'b1);
        verify("R4");
    endtask

    task automatic t_crc();
        clr_cap();
        crc_in = 16'hBEEF;
        send_word(16'h9904);
        tick(2);
        crc_in = 16'h0000;
        tick(3);
        push(8'hBE, 2'd0, 1'b1, 1'b0);
        push(8'hEF, 2'd0, 1'b1, 1'b0);
        verify("R6");
    endtask

    function automatic logic [7:0] raw_pat(input int j);
        if (j == 1) return 8'h08;
        return 8'((j * 37 + 'h99) & 'hFF);
    endfunction

    task automatic t_raw();
        clr_cap();
        send_word(16'h990F);
        for (int w = 0; w < 256; w++) send_word({raw_pat(2*w), raw_pat(2*w+1)});
        send_word(16'h99A1);
        tick(4);
        for (int j = 0; j < 512; j++) push(raw_pat(j), 2'd0, 1'b0, 1'b0);
        push(8'hA1, 2'd1, 1'b0, 1'b1);
        verify("R5");
        chk(wr_gate == 1'b1, "R5", "gate held through raw run", wr_gate, 1);
    endtask

    task automatic t_bad_cmd();
        clr_cap();
        send_word(16'h9955);
        tick(3);
        chk(cmd_err == 1'b1, "R9", "error on undefined command", cmd_err, 1);
        chk(cap_n == 0, "R9", "no output for undefined command", cap_n, 0);
        send_word(16'h7777);
        tick(3);
        push(8'h77, 2'd0, 1'b0, 1'b0);
        push(8'h77, 2'd0, 1'b0, 1'b0);
        verify("R9");
        chk(cmd_err == 1'b1, "R9", "error stays set", cmd_err, 1);
    endtask

    task automatic t_stop();
        clr_cap();
        send_word(16'h9908);
        tick(1);
        chk(wr_gate == 1'b1, "R7", "gate at edge k+1", wr_gate, 1);
        tick(1);
        chk(wr_gate == 1'b0, "R7", "gate at edge k+2", wr_gate, 0);
        send_word(16'h4242);
        tick(4);
        chk(cap_n == 0, "R8", "bytes after stop discarded", cap_n, 0);
        chk(in_ready == 1'b1, "R8", "in_ready after discard", in_ready, 1);
    endtask

    task automatic t_restart();
        pulse_start();
        chk(wr_gate == 1'b1, "R10", "gate after restart", wr_gate, 1);
        chk(cmd_err == 1'b0, "R10", "error cleared by start", cmd_err, 0);
        clr_cap();
        send_word(16'h0102);
        tick(4);
        push(8'h01, 2'd0, 1'b0, 1'b0);
        push(8'h02, 2'd0, 1'b0, 1'b0);
        verify("R10");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_idle_discard();
        t_start();
        t_latency();
        t_backpressure();
        t_preamble();
        t_marks();
        t_crc();
        t_raw();
        t_bad_cmd();
        t_stop();
        t_restart();
        chk(gate_viol == 0, "R12", "output valid with gate low", gate_viol, 0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule